// File: doc/BRIEF.md
# Windowed SRAM-to-FIFO Prefetch Loader

This block copies a contiguous window of words out of a single-port synchronous SRAM and places them, in address order, into a local transmit FIFO. A consumer on the far side drains the FIFO later. Software first fills the SRAM from the writing side. It then programs a base address and a word count and raises a level-sensitive `go` control. The loader reads the window one word per granted cycle. It never writes the memory.

Every read asks a shared-memory arbiter for access. A read is issued only in a cycle where the grant is present. The synchronous SRAM returns the word one cycle later, and the loader pushes it into the FIFO in that same cycle. Each word passes either unchanged or through an external transform stage, such as a cipher, that hangs on a combinational hook. The transform select is sampled when the transfer starts. The loader holds off new reads whenever the FIFO could not take the word. When the last word of the window has been written, it raises `done`.

Top module: `pfl_loader`

## Requirements
- R1: After reset, `done` is 0, `fifo_empty` is 1, `fifo_full` is 0, and neither `arb_req` nor `mem_re` is asserted.
- R2: A rising edge of `go` (sampled at a clock edge) latches `base_addr` and `word_count`. Reads then go to base, base+1, base+2 and so on, wrapping modulo 2^AW, with no address skipped or repeated.
- R3: `mem_re` is asserted only in a cycle where `arb_gnt` is 1. A withheld grant delays the next read but does not change its address.
- R4: The word returned for a read is written into the FIFO at the clock edge that ends the cycle after the read. FIFO output order equals read order, with no word dropped or duplicated.
- R5: The FIFO never holds more than DEPTH words. The loader stops reading while no room is guaranteed and resumes once words are popped.
- R6: If `xform_sel` is 1 at the start edge, every stored word is `xf_res` computed from that word (`xf_src` carries the raw SRAM word). Otherwise the raw word is stored. Changing `xform_sel` during a transfer has no effect on that transfer.
- R7: `done` becomes 1 from the clock edge that writes the last word of the window and stays 1 while `go` remains high. No further read is issued after the window is exhausted.
- R8: `done` returns to 0 at the first clock edge where `go` is sampled low. A new rising edge of `go` starts a fresh transfer.
- R9: A word count of zero sets `done` at the clock edge after the start edge and issues no memory read.
- R10: `fifo_pop` removes the head word at a clock edge when the FIFO is non-empty. `fifo_data` always shows the head word. A pop while empty has no effect. `fifo_empty` and `fifo_full` reflect an occupancy of 0 and DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Transfer enable; rising edge starts, low aborts and clears done |
| xform_sel | input | 1 | Route words through the transform hook (sampled at start) |
| base_addr | input | AW | First SRAM word address of the window |
| word_count | input | CW | Number of words in the window |
| arb_req | output | 1 | Loader wants a memory cycle |
| arb_gnt | input | 1 | Arbiter grant for the current cycle |
| mem_re | output | 1 | SRAM read strobe |
| mem_addr | output | AW | SRAM read address |
| mem_rdata | input | DW | SRAM read data, valid the cycle after `mem_re` |
| xf_src | output | DW | Raw word offered to the transform stage |
| xf_res | input | DW | Transformed word returned by the transform stage |
| fifo_pop | input | 1 | Remove head word from the FIFO |
| fifo_data | output | DW | FIFO head word |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| done | output | 1 | Whole window written into the FIFO |

## Verification
The bench builds the loader with AW=6, CW=7, DW=32 and DEPTH=4. A 64-word address space lets a window that starts near the top wrap back to address 0. A four-entry FIFO fills within a few cycles, so windows of 12 to 40 words under a slow or stalled consumer keep the room check and the resume path busy. Random grant and pop densities push read issue and FIFO draining into many relative alignments. Two further cases, a zero-length window and a transform select flipped in mid-transfer, cover the start-edge corners.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_RUN  = 2'd1,
        LD_FIN  = 2'd2
    } ld_state_e;

    // Next sequential address with natural wrap at the address width.
    function automatic logic [15:0] addr_inc(input logic [15:0] a);
        return a + 16'd1;
    endfunction

    // True when occupancy plus words in flight leaves room for one more.
    function automatic logic has_room(input int unsigned level,
                                      input int unsigned in_flight,
                                      input int unsigned depth);
        return (level + in_flight + 1) <= depth;
    endfunction

endpackage

// File: rtl/pfl_fifo.sv
module pfl_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_wr, do_rd;

    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = store[rp];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            store[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_rd) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/pfl_capture.sv
module pfl_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mem_re,
    input  logic          mode,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] xf_res,
    output logic [DW-1:0] xf_src,
    output logic          rvalid,
    output logic [DW-1:0] push_data
);
    // The SRAM output register is the capture point: the flag below
    // marks the cycle in which mem_rdata carries the requested word.
    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= mem_re;
        end
    end

    assign xf_src    = mem_rdata;
    assign push_data = mode ? xf_res : mem_rdata;

endmodule

// File: rtl/pfl_fetch.sv
module pfl_fetch
    import pfl_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CW    = 9,
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          xform_sel,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] word_count,
    input  logic          arb_gnt,
    input  logic [LW-1:0] level,
    input  logic          rvalid,
    output logic          arb_req,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic          mode,
    output logic          start_pulse
);
    ld_state_e     state;
    logic          go_q;
    logic [AW-1:0] cur;
    logic [CW-1:0] issue_left;
    logic [CW-1:0] push_left;
    logic          room;

    assign start_pulse = go && !go_q;
    assign room        = has_room(int'(level), int'(rvalid), DEPTH);
    assign arb_req     = (state == LD_RUN) && go && (issue_left != '0) && room;
    assign mem_re      = arb_req && arb_gnt;
    assign mem_addr    = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q <= 1'b0;
        end else begin
            go_q <= go;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= LD_IDLE;
            cur        <= '0;
            issue_left <= '0;
            push_left  <= '0;
            done       <= 1'b0;
            mode       <= 1'b0;
        end else begin
            case (state)
                LD_IDLE: begin
                    done <= 1'b0;
                    if (start_pulse) begin
                        cur        <= base_addr;
                        issue_left <= word_count;
                        push_left  <= word_count;
                        mode       <= xform_sel;
                        if (word_count == '0) begin
                            done  <= 1'b1;
                            state <= LD_FIN;
                        end else begin
                            state <= LD_RUN;
                        end
                    end
                end
                LD_RUN: begin
                    if (!go) begin
                        done  <= 1'b0;
                        state <= LD_IDLE;
                    end else begin
                        if (mem_re) begin
                            cur        <= AW'(addr_inc(16'(cur)));
                            issue_left <= issue_left - 1'b1;
                        end
                        if (rvalid) begin
                            push_left <= push_left - 1'b1;
                            if (push_left == CW'(1)) begin
                                done  <= 1'b1;
                                state <= LD_FIN;
                            end
                        end
                    end
                end
                LD_FIN: begin
                    if (!go) begin
                        done  <= 1'b0;
                        state <= LD_IDLE;
                    end
                end
                default: begin
                    done  <= 1'b0;
                    state <= LD_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pfl_loader.sv
module pfl_loader #(
    parameter int AW    = 8,
    parameter int CW    = AW + 1,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          xform_sel,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] word_count,
    output logic          arb_req,
    input  logic          arb_gnt,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] xf_src,
    input  logic [DW-1:0] xf_res,
    input  logic          fifo_pop,
    output logic [DW-1:0] fifo_data,
    output logic          fifo_empty,
    output logic          fifo_full,
    output logic          done
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0] level;
    logic          rvalid;
    logic          push;
    logic [DW-1:0] push_data;
    logic          mode;
    logic          start_pulse;

    assign push = rvalid;

    pfl_fetch #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .LW(LW)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .go          (go),
        .xform_sel   (xform_sel),
        .base_addr   (base_addr),
        .word_count  (word_count),
        .arb_gnt     (arb_gnt),
        .level       (level),
        .rvalid      (rvalid),
        .arb_req     (arb_req),
        .mem_re      (mem_re),
        .mem_addr    (mem_addr),
        .done        (done),
        .mode        (mode),
        .start_pulse (start_pulse)
    );

    pfl_capture #(.DW(DW)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .mem_re    (mem_re),
        .mode      (mode),
        .mem_rdata (mem_rdata),
        .xf_res    (xf_res),
        .xf_src    (xf_src),
        .rvalid    (rvalid),
        .push_data (push_data)
    );

    pfl_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (push),
        .wdata (push_data),
        .rd    (fifo_pop),
        .rdata (fifo_data),
        .level (level),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

endmodule

// File: rtl/pfl_checker.sv
module pfl_checker #(
    parameter int AW = 8,
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          go,
    input logic          start_pulse,
    input logic [CW-1:0] word_count,
    input logic          arb_gnt,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          push,
    input logic          fifo_full,
    input logic          done
);
    logic [AW-1:0] last_addr;
    logic          have_last;

    always_ff @(posedge clk) begin
        if (rst || start_pulse) begin
            have_last <= 1'b0;
            last_addr <= '0;
        end else if (mem_re) begin
            have_last <= 1'b1;
            last_addr <= mem_addr;
        end
    end

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_re && have_last) |-> (mem_addr == AW'(last_addr + 1'b1)));

    assert_read_granted_R3: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> arb_gnt);

    assert_capture_next_R4: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> push);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        push |-> !fifo_full);

    assert_done_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !go |=> !done);

    assert_zero_done_R9: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && word_count == '0) |=> done);

    assert_zero_noread_R9: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && word_count == '0) |=> !mem_re);

endmodule

bind pfl_loader pfl_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .start_pulse (start_pulse),
    .word_count  (word_count),
    .arb_gnt     (arb_gnt),
    .mem_re      (mem_re),
    .mem_addr    (mem_addr),
    .push        (push),
    .fifo_full   (fifo_full),
    .done        (done)
);

// File: tb/sim_pfl_loader.sv
module sim_pfl_loader;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int CW    = 7;
    localparam int DW    = 32;
    localparam int DEPTH = 4;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          go;
    logic          xform_sel;
    logic [AW-1:0] base_addr;
    logic [CW-1:0] word_count;
    logic          arb_req;
    logic          arb_gnt;
    logic          mem_re;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] xf_src;
    logic [DW-1:0] xf_res;
    logic          fifo_pop;
    logic [DW-1:0] fifo_data;
    logic          fifo_empty;
    logic          fifo_full;
    logic          done;

    pfl_loader #(.AW(AW), .CW(CW), .DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .go(go), .xform_sel(xform_sel),
        .base_addr(base_addr), .word_count(word_count),
        .arb_req(arb_req), .arb_gnt(arb_gnt),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .xf_src(xf_src), .xf_res(xf_res),
        .fifo_pop(fifo_pop), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DW-1:0] xf_fn(input logic [DW-1:0] w);
        return {w[15:0], w[31:16]} ^ 32'hA5C3_0F1E;
    endfunction

    assign xf_res = xf_fn(xf_src);

    // Behavioural SRAM with one-cycle read latency.
    logic [DW-1:0] sram [WORDS];
    initial begin
        for (int i = 0; i < WORDS; i++) begin
            sram[i] = 32'h1357_0000 + i * 32'h0001_0203 + (i << 24);
        end
    end
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= sram[mem_addr];
    end

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    int            m_cnt = 0;
    int            m_pushed = 0;
    int            m_issued = 0;
    int            m_range = 0;
    bit            m_active = 0;
    bit            m_mode = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] expq [$];
    bit re_d1 = 0, re_d2 = 0, pop_prev = 0, go_prev = 0, go_prev2 = 0;

    // Commands applied in the drive phase of each step
    bit            go_cmd = 0;
    bit            mode_cmd = 0;
    logic [AW-1:0] base_cmd = '0;
    logic [CW-1:0] cnt_cmd = '0;
    int unsigned   seed = 32'h1234_5678;

    function automatic int rnd100();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return int'(seed % 100);
    endfunction

    task automatic step(input int gnt_pct, input int pop_pct);
        int  c0;
        bit  p;
        bit  g;
        @(negedge clk);
        cycles++;
        // account for the clock edge just passed
        if (go_prev && !go_prev2) begin
            m_active = 1; m_pushed = 0; m_issued = 0;
            m_addr = base_addr; m_range = int'(word_count); m_mode = xform_sel;
        end else if (!go_prev) begin
            m_active = 0;
        end
        c0 = m_cnt;
        if (pop_prev && c0 > 0) m_cnt--;
        if (re_d2) begin m_cnt++; m_pushed++; end
        // registered outputs
        chk(done == (m_active && m_pushed == m_range), "R7/R8/R9 done", DW'(done),
            DW'(m_active && m_pushed == m_range));
        chk(fifo_empty == (m_cnt == 0), "R10 empty", DW'(fifo_empty), DW'(m_cnt == 0));
        chk(fifo_full == (m_cnt == DEPTH), "R5 full", DW'(fifo_full), DW'(m_cnt == DEPTH));
        chk(m_cnt <= DEPTH, "R5 occupancy", DW'(m_cnt), DW'(DEPTH));
        // drive inputs
        g = (rnd100() < gnt_pct);
        p = (rnd100() < pop_pct);
        if (p && m_cnt > 0) begin
            chk(expq.size() > 0 && fifo_data == expq[0], "R4/R6 head data",
                fifo_data, (expq.size() > 0) ? expq[0] : 'x);
            if (expq.size() > 0) void'(expq.pop_front());
        end
        arb_gnt    = g;
        fifo_pop   = p;
        go         = go_cmd;
        xform_sel  = mode_cmd;
        base_addr  = base_cmd;
        word_count = cnt_cmd;
        #1;
        if (mem_re) begin
            chk(arb_gnt, "R3 read without grant", DW'(arb_gnt), 32'd1);
            chk(mem_addr == m_addr, "R2 read address", DW'(mem_addr), DW'(m_addr));
            chk(m_active && m_issued < m_range, "R7/R9 extra read",
                DW'(m_issued), DW'(m_range));
            expq.push_back(m_mode ? xf_fn(sram[m_addr]) : sram[m_addr]);
            m_addr = m_addr + 1'b1;
            m_issued++;
        end
        re_d2    = re_d1;
        re_d1    = mem_re;
        pop_prev = p;
        go_prev2 = go_prev;
        go_prev  = go;
    endtask

    task automatic run_xfer(input int base, input int n, input bit mode,
                            input int gnt_pct, input int pop_pct,
                            input int stall, input bit flip_mode);
        int k;
        go_cmd = 0; base_cmd = AW'(base); cnt_cmd = CW'(n); mode_cmd = mode;
        repeat (2) step(gnt_pct, pop_pct);
        go_cmd = 1;
        k = 0;
        while (k < 3000) begin
            if (flip_mode && k == 4) mode_cmd = !mode;   // R6: ignored mid-run
            step(gnt_pct, (k < stall) ? 0 : pop_pct);
            k++;
            if (done && m_cnt == 0 && m_pushed == n) break;
        end
        chk(done == 1'b1, "R7 transfer completed", DW'(done), 32'd1);
        chk(m_pushed == n, "R4 word count pushed", DW'(m_pushed), DW'(n));
        go_cmd = 0;
        step(gnt_pct, pop_pct);
        step(gnt_pct, pop_pct);
        chk(done == 1'b0, "R8 done cleared by go low", DW'(done), 32'd0);
    endtask

    initial begin
        rst = 1'b1; go = 0; xform_sel = 0; base_addr = '0; word_count = '0;
        arb_gnt = 0; fifo_pop = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(done == 0, "R1 done", DW'(done), 32'd0);
        chk(fifo_empty == 1, "R1 empty", DW'(fifo_empty), 32'd1);
        chk(fifo_full == 0, "R1 full", DW'(fifo_full), 32'd0);
        chk(arb_req == 0 && mem_re == 0, "R1 no request", DW'({arb_req, mem_re}), 32'd0);

        // R10: pops while empty have no effect
        repeat (4) step(0, 100);
        // R2/R4: simple window, full grant and fast drain
        run_xfer(3, 10, 0, 100, 100, 0, 0);
        // R2/R3/R6: wrap past the top, sparse grant, slow drain, mode flip ignored
        run_xfer(58, 12, 1, 50, 30, 0, 1);
        // R9: zero-length window
        run_xfer(20, 0, 0, 100, 100, 0, 0);
        // R5: long window with a stalled consumer
        run_xfer(0, 40, 1, 80, 60, 30, 0);
        // R8: immediate restart with a different window
        run_xfer(33, 7, 0, 70, 90, 5, 0);
        run_xfer(63, 64, 1, 60, 50, 10, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired after %0d steps", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule